// File: doc/BRIEF.md
# Iterative Integer Divide/Remainder Unit

This block is the divide unit of an integer core. On a start pulse it captures two operands and a two-bit operation select, and after a number of cycles it delivers either the quotient or the remainder. The operation can be signed or unsigned. Quotients are truncated toward zero. The register width is a parameter, either 32 or 64. With a 64-bit width a word flag selects the 32-bit forms. These read only the low 32 bits of each operand and return a 32-bit result sign-extended to 64 bits.

The unit never traps. A zero divisor and the signed case of the most negative value divided by -1 each produce a fixed result, and both finish in a single cycle. All other operations work on operand magnitudes with a radix-2 restoring loop, which produces one quotient bit per cycle. Signs are restored in one final cycle.

The controller has three states. ST_IDLE waits for work. ST_DIVIDE runs the iterations. ST_SIGN applies the signs and sign extension.

The transitions are:
- idle-to-divide: on start with an ordinary operand pair.
- idle-to-idle with an immediate result: on start with a special operand pair.
- divide-to-sign: when the final iteration is taken.
- sign-to-idle: unconditional, and raises done.

Top module: `intdiv_unit`

## Requirements
- R1: The select input op[1:0] matches the low two bits of the instruction function field. op[1]=0 selects the quotient and op[1]=1 the remainder. op[0]=0 selects signed and op[0]=1 unsigned. The quotient rounds toward zero.
- R2: The remainder has the sign of the dividend, and its magnitude is below the divisor magnitude.
- R3: A zero divisor gives a quotient of all ones and a remainder equal to the dividend.
- R4: In signed mode, the most negative value divided by -1 gives the most negative value as quotient and zero as remainder.
- R5: A zero-divisor or signed-overflow operation raises done in the cycle after the start edge, and busy stays low.
- R6: Any other operation keeps busy high from the start edge for W+1 cycles. Done rises W+2 cycles after the start was driven. W is 32 for word forms and the register width otherwise.
- R7: With word=1 (64-bit width only), only bits 31..0 of each operand are used. The 32-bit result is sign-extended to 64 bits, for the unsigned forms as well.
- R8: Word forms apply the R3 and R4 rules at 32 bits before sign extension.
- R9: A start while busy is ignored. The running operation completes unchanged and on time.
- R10: Done is a one-cycle pulse. The result only changes together with done and holds until the next done.
- R11: During reset busy, done and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled in ST_IDLE |
| op_i | input | 2 | Bit 1 selects remainder, bit 0 selects unsigned |
| word_i | input | 1 | Selects the 32-bit word forms (64-bit width only) |
| dividend_i | input | XLEN | Dividend |
| divisor_i | input | XLEN | Divisor |
| busy_o | output | 1 | High while an iterative operation runs |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | XLEN | Quotient or remainder, held until the next done |

## Verification
The bench runs small operands in all four sign combinations. A truncating quotient and a dividend-signed remainder (-7/2 = -3 rem -1) then differ visibly from a floor convention, and each of the four select codes is separated. Zero divisors and most-negative-by-minus-one pairs are run at both widths, with junk in the upper halves for word forms. This shows whether the fixed results are taken at the right width and whether unsigned word results are sign-extended. Random operand pairs across all codes and both widths are compared against an arithmetic reference computed in the bench, along with the latency and hold behaviour of each operation. A start driven mid-division checks that the running operation is neither corrupted nor delayed.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SIGN   = 2'd2
    } div_state_e;

    typedef struct packed {
        logic rem_sel;    // 1: remainder, 0: quotient
        logic is_signed;  // operands interpreted as two's complement
        logic word;       // 32-bit form on a wider register
        logic a_neg;      // dividend negative
        logic b_neg;      // divisor negative
    } div_ctl_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CW   = $clog2(XLEN + 1)
) (
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output div_ctl_t        ctl_o,
    output logic [XLEN-1:0] dvd_mag_o,
    output logic [XLEN-1:0] dvs_mag_o,
    output logic [CW-1:0]   iters_o,
    output logic            special_o,
    output logic [XLEN-1:0] sp_quo_o,
    output logic [XLEN-1:0] sp_rem_o
);
    localparam int HW = 32;

    logic            is_signed;
    logic            word_eff;
    logic [XLEN-1:0] a_w, b_w;
    logic [XLEN-1:0] a_ext, b_ext;
    logic            a_neg, b_neg;
    logic [XLEN-1:0] a_mag, b_mag;
    logic            b_zero, a_min, b_m1, ovf;

    assign is_signed = ~op_i[0];

    generate
        if (XLEN > HW) begin : g_wide
            assign word_eff = word_i;
            assign a_w = is_signed ? {{(XLEN-HW){a_i[HW-1]}}, a_i[HW-1:0]}
                                   : {{(XLEN-HW){1'b0}}, a_i[HW-1:0]};
            assign b_w = is_signed ? {{(XLEN-HW){b_i[HW-1]}}, b_i[HW-1:0]}
                                   : {{(XLEN-HW){1'b0}}, b_i[HW-1:0]};
        end else begin : g_narrow
            assign word_eff = 1'b0;
            assign a_w      = a_i;
            assign b_w      = b_i;
        end
    endgenerate

    always_comb begin
        a_ext = word_eff ? a_w : a_i;
        b_ext = word_eff ? b_w : b_i;
        a_neg = is_signed & (word_eff ? a_i[HW-1] : a_i[XLEN-1]);
        b_neg = is_signed & (word_eff ? b_i[HW-1] : b_i[XLEN-1]);
        a_mag = a_neg ? (~a_ext + 1'b1) : a_ext;
        b_mag = b_neg ? (~b_ext + 1'b1) : b_ext;

        // word dividends start in the upper half so only 32 steps are needed
        dvd_mag_o = word_eff ? (a_mag << HW) : a_mag;
        dvs_mag_o = b_mag;
        iters_o   = word_eff ? CW'(HW) : CW'(XLEN);

        b_zero = word_eff ? (b_i[HW-1:0] == '0) : (b_i == '0);
        a_min  = word_eff ? (a_i[HW-1:0] == {1'b1, {(HW-1){1'b0}}})
                          : (a_i == {1'b1, {(XLEN-1){1'b0}}});
        b_m1   = word_eff ? (b_i[HW-1:0] == '1) : (b_i == '1);
        ovf    = is_signed & a_min & b_m1;

        special_o = b_zero | ovf;
        if (b_zero) begin
            sp_quo_o = '1;
            sp_rem_o = a_ext;
        end else begin
            sp_quo_o = a_ext;
            sp_rem_o = '0;
        end

        ctl_o.rem_sel   = op_i[1];
        ctl_o.is_signed = is_signed;
        ctl_o.word      = word_eff;
        ctl_o.a_neg     = a_neg;
        ctl_o.b_neg     = b_neg;
    end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int XLEN = 64,
    parameter int CW   = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dvs_i,
    input  logic [CW-1:0]   iters_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o,
    output logic            last_o
);
    logic [XLEN-1:0] quo_q, rem_q, dvs_q;
    logic [CW-1:0]   cnt_q, iters_q;
    logic [XLEN:0]   shifted, trial;

    assign shifted = {rem_q, quo_q[XLEN-1]};
    assign trial   = shifted - {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            iters_q <= '0;
        end else if (load_i) begin
            quo_q   <= dvd_i;
            rem_q   <= '0;
            dvs_q   <= dvs_i;
            cnt_q   <= '0;
            iters_q <= iters_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (!trial[XLEN]) begin
                rem_q <= trial[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= shifted[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    assign quo_o  = quo_q;
    assign rem_o  = rem_q;
    assign last_o = (cnt_q == iters_q - 1'b1);

    // the controller never asks for more iterations than were loaded
    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q < iters_q));

    // partial remainder stays below the divisor after each step
    p_rem_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (rem_q < dvs_q));

endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    input  logic            rem_sel_i,
    input  logic            q_neg_i,
    input  logic            r_neg_i,
    input  logic            apply_i,
    input  logic            word_i,
    output logic [XLEN-1:0] res_o
);
    localparam int HW = 32;

    logic [XLEN-1:0] sel, val;
    logic            neg;

    always_comb begin
        sel = rem_sel_i ? rem_i : quo_i;
        neg = apply_i & (rem_sel_i ? r_neg_i : q_neg_i);
        val = neg ? (~sel + 1'b1) : sel;
    end

    generate
        if (XLEN > HW) begin : g_ext
            assign res_o = word_i ? {{(XLEN-HW){val[HW-1]}}, val[HW-1:0]} : val;
        end else begin : g_plain
            assign res_o = val;
        end
    endgenerate

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int CW = $clog2(XLEN + 1);

    div_state_e      state_q, state_d;
    div_ctl_t        ctl_q, prep_ctl, fix_ctl;
    logic [XLEN-1:0] dvd_mag, dvs_mag, sp_quo, sp_rem;
    logic [XLEN-1:0] core_quo, core_rem, fix_quo, fix_rem, fix_res;
    logic [CW-1:0]   iters;
    logic            special, last, load, step, in_idle;
    logic [XLEN-1:0] result_q;
    logic            done_q;

    intdiv_prep #(.XLEN(XLEN), .CW(CW)) u_prep (
        .op_i      (op_i),
        .word_i    (word_i),
        .a_i       (dividend_i),
        .b_i       (divisor_i),
        .ctl_o     (prep_ctl),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .iters_o   (iters),
        .special_o (special),
        .sp_quo_o  (sp_quo),
        .sp_rem_o  (sp_rem)
    );

    assign in_idle = (state_q == ST_IDLE);
    assign load    = in_idle & start_i & ~special;
    assign step    = (state_q == ST_DIVIDE);

    intdiv_core #(.XLEN(XLEN), .CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .dvd_i   (dvd_mag),
        .dvs_i   (dvs_mag),
        .iters_i (iters),
        .quo_o   (core_quo),
        .rem_o   (core_rem),
        .last_o  (last)
    );

    // idle: fixed results straight from the operands; otherwise loop output
    assign fix_ctl = in_idle ? prep_ctl : ctl_q;
    assign fix_quo = in_idle ? sp_quo : core_quo;
    assign fix_rem = in_idle ? sp_rem : core_rem;

    intdiv_fix #(.XLEN(XLEN)) u_fix (
        .quo_i     (fix_quo),
        .rem_i     (fix_rem),
        .rem_sel_i (fix_ctl.rem_sel),
        .q_neg_i   (fix_ctl.a_neg ^ fix_ctl.b_neg),
        .r_neg_i   (fix_ctl.a_neg),
        .apply_i   (~in_idle),
        .word_i    (fix_ctl.word),
        .res_o     (fix_res)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i && !special) state_d = ST_DIVIDE;
            ST_DIVIDE: if (last) state_d = ST_SIGN;
            ST_SIGN:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and captured control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl_q <= prep_ctl;
                        if (special) begin
                            result_q <= fix_res;
                            done_q   <= 1'b1;
                        end
                    end
                end
                ST_DIVIDE: ;
                ST_SIGN: begin
                    result_q <= fix_res;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o   = ~in_idle;
    assign done_o   = done_q;
    assign result_o = result_q;

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q));

    p_special_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && start_i && special) |=> (done_o && !busy_o));

endmodule

// File: tb/sim_intdiv_unit.sv
module sim_intdiv_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op = '0;
    logic            word = 1'b0;
    logic [XLEN-1:0] a = '0, b = '0;
    logic            busy, done;
    logic [XLEN-1:0] result;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intdiv_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .word_i(word),
        .dividend_i(a), .divisor_i(b),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic is_special(input logic [63:0] x, input logic [63:0] y,
                                        input logic [1:0] o, input logic w);
        if (w) return (y[31:0] == 0) || (!o[0] && x[31:0] == 32'h8000_0000 && y[31:0] == 32'hFFFF_FFFF);
        return (y == 0) || (!o[0] && x == 64'h8000_0000_0000_0000 && y == '1);
    endfunction

    function automatic logic [63:0] ref_div(input logic [63:0] x, input logic [63:0] y,
                                            input logic [1:0] o, input logic w);
        logic [31:0] v32;
        logic [63:0] v64;
        int          s1, s2;
        longint      l1, l2;
        if (w) begin
            if (y[31:0] == 0) v32 = o[1] ? x[31:0] : 32'hFFFF_FFFF;
            else if (!o[0] && x[31:0] == 32'h8000_0000 && y[31:0] == 32'hFFFF_FFFF)
                v32 = o[1] ? 32'h0 : 32'h8000_0000;
            else if (!o[0]) begin
                s1 = x[31:0]; s2 = y[31:0];
                v32 = o[1] ? (s1 % s2) : (s1 / s2);
            end else
                v32 = o[1] ? (x[31:0] % y[31:0]) : (x[31:0] / y[31:0]);
            return {{32{v32[31]}}, v32};
        end
        if (y == 0) v64 = o[1] ? x : '1;
        else if (!o[0] && x == 64'h8000_0000_0000_0000 && y == '1)
            v64 = o[1] ? 64'h0 : x;
        else if (!o[0]) begin
            l1 = x; l2 = y;
            v64 = o[1] ? (l1 % l2) : (l1 / l2);
        end else
            v64 = o[1] ? (x % y) : (x / y);
        return v64;
    endfunction

    // one operation: result, latency and post-done hold are checked
    task automatic run_op(input logic [63:0] x, input logic [63:0] y,
                          input logic [1:0] o, input logic w, input string tag);
        int          cyc;
        int          exp_lat;
        logic [63:0] held;
        @(negedge clk);
        a = x; b = y; op = o; word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        exp_lat = is_special(x, y, o, w) ? 1 : ((w ? 32 : 64) + 2);
        chk(tag, result, ref_div(x, y, o, w));
        chk(is_special(x, y, o, w) ? "R5 latency" : "R6 latency", 64'(cyc), 64'(exp_lat));
        held = result;
        @(negedge clk);
        chk("R10 done pulse", {63'b0, done}, 64'd0);
        chk("R10 result hold", result, held);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 busy", {63'b0, busy}, 64'd0);
        chk("R11 done", {63'b0, done}, 64'd0);
        chk("R11 result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_signs();
        run_op(64'd100, 64'd7, 2'b00, 1'b0, "R1 signed quo");
        run_op(64'd100, 64'd7, 2'b01, 1'b0, "R1 unsigned quo");
        run_op(64'd100, 64'd7, 2'b10, 1'b0, "R1 signed rem");
        run_op(64'd100, 64'd7, 2'b11, 1'b0, "R1 unsigned rem");
        run_op(-64'sd7, 64'd2, 2'b00, 1'b0, "R1 -7/2 quo");
        run_op(-64'sd7, 64'd2, 2'b10, 1'b0, "R2 -7%2 rem");
        run_op(64'd7, -64'sd2, 2'b00, 1'b0, "R1 7/-2 quo");
        run_op(64'd7, -64'sd2, 2'b10, 1'b0, "R2 7%-2 rem");
        run_op(-64'sd7, -64'sd2, 2'b00, 1'b0, "R1 -7/-2 quo");
        run_op(-64'sd7, -64'sd2, 2'b10, 1'b0, "R2 -7%-2 rem");
        run_op(-64'sd7, 64'd2, 2'b01, 1'b0, "R1 unsigned big quo");
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0, "R2 unsigned max rem");
    endtask

    task automatic t_divzero();
        run_op(64'h1234_5678_9ABC_DEF0, 64'd0, 2'b00, 1'b0, "R3 quo signed");
        run_op(64'h1234_5678_9ABC_DEF0, 64'd0, 2'b01, 1'b0, "R3 quo unsigned");
        run_op(-64'sd5, 64'd0, 2'b10, 1'b0, "R3 rem signed");
        run_op(-64'sd5, 64'd0, 2'b11, 1'b0, "R3 rem unsigned");
    endtask

    task automatic t_overflow();
        run_op(64'h8000_0000_0000_0000, '1, 2'b00, 1'b0, "R4 quo");
        run_op(64'h8000_0000_0000_0000, '1, 2'b10, 1'b0, "R4 rem");
        run_op(64'h8000_0000_0000_0000, '1, 2'b01, 1'b0, "R4 unsigned not special");
    endtask

    task automatic t_word();
        chk("R7 ref sign-ext unsigned", ref_div(64'hAAAA_0000_F000_0000, 64'h5555_0000_0000_0001, 2'b01, 1'b1),
            64'hFFFF_FFFF_F000_0000);
        run_op(64'hAAAA_0000_F000_0000, 64'h5555_0000_0000_0001, 2'b01, 1'b1, "R7 unsigned word sext");
        run_op(64'hDEAD_BEEF_FFFF_FFF9, 64'h1111_1111_0000_0002, 2'b00, 1'b1, "R7 signed word quo");
        run_op(64'hDEAD_BEEF_FFFF_FFF9, 64'h1111_1111_0000_0002, 2'b10, 1'b1, "R7 signed word rem");
        run_op(64'h0000_0001_8000_0001, 64'hFFFF_FFFF_0000_0000, 2'b11, 1'b1, "R8 word zero div rem");
        run_op(64'h0000_0001_8000_0001, 64'hFFFF_FFFF_0000_0000, 2'b00, 1'b1, "R8 word zero div quo");
        run_op(64'h7777_7777_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'b00, 1'b1, "R8 word overflow quo");
        run_op(64'h7777_7777_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'b10, 1'b1, "R8 word overflow rem");
    endtask

    task automatic t_busy_ignore();
        int          cyc;
        logic [63:0] exp;
        exp = ref_div(64'd1000, 64'd7, 2'b00, 1'b0);
        @(negedge clk);
        a = 64'd1000; b = 64'd7; op = 2'b00; word = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (5) begin @(negedge clk); cyc++; end
        chk("R9 busy mid-run", {63'b0, busy}, 64'd1);
        a = 64'd5; b = 64'd0; op = 2'b10; start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk("R9 result unchanged", result, exp);
        chk("R9 latency unchanged", 64'(cyc), 64'd66);
        @(negedge clk);
    endtask

    task automatic t_random();
        logic [63:0] x, y;
        for (int i = 0; i < 160; i++) begin
            x = {$urandom, $urandom};
            y = {$urandom, $urandom} >> ($urandom % 64);
            if (i % 7 == 0) x = -x;
            run_op(x, y, 2'(i), 1'(i >> 2), "R1 R2 R7 random");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_signs();
        t_divzero();
        t_overflow();
        t_word();
        t_busy_ignore();
        t_random();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule